// File: doc/BRIEF.md
# Guest/Hypervisor Interrupt Steering Unit

This block sits beside one processor core. It decides which interrupts the core takes and at which handling level each one lands, either the hypervisor or the guest kernel. It keeps the core's current privilege mode. There are three modes: guest user, guest supervisor and hypervisor. Each external interrupt source has a steering bit. The bit sends the source either straight to the guest or into a trap at hypervisor level.

Every event is first latched into a pending bit. Guest-directed work is held back while the core runs at hypervisor level, and it is delivered without any further action once the core drops back into a guest mode. The block also covers a doorbell that the hypervisor posts to the guest, a trap raised when a guest touches a hypervisor-only resource, and a system call that goes either to the guest kernel or to the hypervisor, chosen by its operand. A return-from-interrupt input restores the mode that was saved when the current level was entered.

In each cycle the block presents at most one take strobe, with the target level and a cause number. At the next clock edge the taken event's pending bit is cleared and the mode switches.

Top module: `irq_steer_unit`

## Requirements
- R1: After reset, `mode_o` reads hypervisor (2), no event is pending, `take_o` is low and every source is steered to the hypervisor.
- R2: `mode_o` encodes guest user as 0, guest supervisor as 1 and hypervisor as 2. The edge that takes a hypervisor-level event sets the mode to 2. The edge that takes a guest-level event sets it to 1.
- R3: When `cfg_we_i` is high in hypervisor mode, the steering register is loaded from `cfg_steer_i` (bit i = 1 sends source i to the guest, 0 to the hypervisor). A write made in a guest mode is ignored.
- R4: An external source steered to the hypervisor is taken at hypervisor level with cause i in any mode, whatever `guest_ie_i` is.
- R5: An external source steered to the guest is taken at guest level with cause i only in a guest mode with `guest_ie_i` = 1. While the core is in hypervisor mode it stays pending, and it is taken as soon as the core returns to a guest mode.
- R6: `priv_trap_i` in a guest mode is always taken at hypervisor level with cause NUM_SRC+1, whatever the steering. In hypervisor mode it is ignored.
- R7: `db_post_i` makes the doorbell pending. The doorbell is taken at guest level with cause NUM_SRC only in a guest mode with `db_en_i` = 1. Until then it stays pending.
- R8: `sc_req_i` in a guest mode with `sc_hcall_i` = 1 is taken at hypervisor level with cause NUM_SRC+2. With `sc_hcall_i` = 0 it is taken at guest level with cause NUM_SRC+3, regardless of `guest_ie_i`. In hypervisor mode it is ignored.
- R9: When events of both levels are eligible, the hypervisor-level one is taken first. Within one level, the lowest cause number wins.
- R10: A request held high before a clock edge becomes pending at that edge. A pending bit is cleared only by the edge on which `take_o` names it, and the winner's competitors stay pending.
- R11: `rfi_i` in hypervisor mode restores the mode saved at the last hypervisor-level take (guest supervisor after reset). In guest supervisor mode it restores the mode saved at the last guest-level take (guest user after reset). In guest user mode, or in a cycle with a take, it has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_req_i | input | NUM_SRC | External interrupt requests, one per source |
| cfg_we_i | input | 1 | Steering register write strobe |
| cfg_steer_i | input | NUM_SRC | Steering value, 1 = guest |
| guest_ie_i | input | 1 | Guest external interrupt enable |
| db_post_i | input | 1 | Hypervisor posts a doorbell |
| db_en_i | input | 1 | Guest doorbell enable |
| priv_trap_i | input | 1 | Guest touched a hypervisor-only resource |
| sc_req_i | input | 1 | System call executed |
| sc_hcall_i | input | 1 | System call operand selects the hypervisor |
| rfi_i | input | 1 | Return from interrupt |
| take_o | output | 1 | An event is taken this cycle |
| take_hv_o | output | 1 | Target level, 1 = hypervisor |
| take_cause_o | output | $clog2(NUM_SRC+4) | Cause number of the taken event |
| mode_o | output | 2 | Current privilege mode |

## Verification
Several rules are checked by assertions on every cycle. The mode always holds a legal encoding and follows each take to the right level. A guest-level take never happens in hypervisor mode. A pending hypervisor-level event always wins. The doorbell is never taken with its enable low. A pending bit never drops except on its own take. Other behaviour depends on history, and only the bench scenarios can show it. This covers deferral of guest events across hypervisor mode and their later delivery, the modes restored by return-from-interrupt, and writes to the steering register that are ignored. The bench sweeps every steering pattern, mode and enable for each source, and then adds directed orderings.

// File: rtl/irq_steer_pkg.sv
package irq_steer_pkg;
  typedef enum logic [1:0] {
    MODE_GU = 2'd0,
    MODE_GS = 2'd1,
    MODE_HV = 2'd2
  } mode_e;
endpackage

// File: rtl/irq_pend_bank.sv
module irq_pend_bank #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] pend_o
);
  logic [W-1:0] pend_q;
  logic [W-1:0] pend_d;

  for (genvar g = 0; g < W; g++) begin : g_bit
    // a new request wins over a clear in the same cycle
    always_comb begin
      pend_d[g] = pend_q[g];
      if (clr_i[g]) pend_d[g] = 1'b0;
      if (set_i[g]) pend_d[g] = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pend_q[g] <= 1'b0;
      else        pend_q[g] <= pend_d[g];
    end

    // R10: a pending bit drops only on the edge that takes it
    assert_drop_only_on_take_R10: assert property (
      @(posedge clk) disable iff (!rst_n)
      $fell(pend_q[g]) |-> $past(clr_i[g]));
  end

  assign pend_o = pend_q;
endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
  parameter int W     = 8,
  parameter int IDX_W = $clog2(W)
) (
  input  logic [W-1:0]     req_i,
  output logic [W-1:0]     gnt_o,
  output logic [IDX_W-1:0] idx_o,
  output logic             any_o
);
  always_comb begin
    idx_o = '0;
    gnt_o = '0;
    for (int i = W - 1; i >= 0; i--) begin
      if (req_i[i]) idx_o = IDX_W'(i);
    end
    any_o = |req_i;
    if (any_o) gnt_o[idx_o] = 1'b1;
    // R9: one winner at most, and it must be a requester
    assert_gnt_onehot_R9: assert ($onehot0(gnt_o));
    assert_gnt_subset_R9: assert ((gnt_o & ~req_i) == '0);
  end
endmodule

// File: rtl/irq_mode_ctrl.sv
module irq_mode_ctrl
  import irq_steer_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  take_i,
  input  logic  take_hv_i,
  input  logic  rfi_i,
  output mode_e mode_o
);
  mode_e mode_q, mode_d;
  mode_e hv_save_q, hv_save_d;
  mode_e gs_save_q, gs_save_d;

  always_comb begin
    mode_d    = mode_q;
    hv_save_d = hv_save_q;
    gs_save_d = gs_save_q;
    if (take_i) begin
      if (take_hv_i) begin
        hv_save_d = mode_q;
        mode_d    = MODE_HV;
      end else begin
        gs_save_d = mode_q;
        mode_d    = MODE_GS;
      end
    end else if (rfi_i) begin
      if (mode_q == MODE_HV)      mode_d = hv_save_q;
      else if (mode_q == MODE_GS) mode_d = gs_save_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q    <= MODE_HV;
      hv_save_q <= MODE_GS;
      gs_save_q <= MODE_GU;
    end else begin
      mode_q    <= mode_d;
      hv_save_q <= hv_save_d;
      gs_save_q <= gs_save_d;
    end
  end

  assign mode_o = mode_q;

  assert_mode_legal_R2: assert property (
    @(posedge clk) disable iff (!rst_n) mode_q != 2'd3);
  assert_hv_take_enters_hv_R2: assert property (
    @(posedge clk) disable iff (!rst_n)
    (take_i && take_hv_i) |=> (mode_q == MODE_HV));
  assert_gs_take_enters_gs_R2: assert property (
    @(posedge clk) disable iff (!rst_n)
    (take_i && !take_hv_i) |=> (mode_q == MODE_GS));
  assert_rfi_user_ignored_R11: assert property (
    @(posedge clk) disable iff (!rst_n)
    (rfi_i && !take_i && mode_q == MODE_GU) |=> (mode_q == MODE_GU));
endmodule

// File: rtl/irq_steer_unit.sv
module irq_steer_unit
  import irq_steer_pkg::*;
#(
  parameter int  NUM_SRC = 4,
  localparam int NCAUSE  = NUM_SRC + 4,
  localparam int CAUSE_W = $clog2(NCAUSE)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src_req_i,
  input  logic               cfg_we_i,
  input  logic [NUM_SRC-1:0] cfg_steer_i,
  input  logic               guest_ie_i,
  input  logic               db_post_i,
  input  logic               db_en_i,
  input  logic               priv_trap_i,
  input  logic               sc_req_i,
  input  logic               sc_hcall_i,
  input  logic               rfi_i,
  output logic               take_o,
  output logic               take_hv_o,
  output logic [CAUSE_W-1:0] take_cause_o,
  output logic [1:0]         mode_o
);
  localparam int C_DB    = NUM_SRC;
  localparam int C_PRIV  = NUM_SRC + 1;
  localparam int C_HCALL = NUM_SRC + 2;
  localparam int C_GSYS  = NUM_SRC + 3;

  // reset: asserted at once, released through two flops
  logic [1:0] rst_sync_q;
  logic       rst_nq;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_nq = rst_sync_q[1];

  mode_e mode;
  logic  in_guest;
  assign in_guest = (mode != MODE_HV);

  // steering register, writable only from hypervisor mode
  logic [NUM_SRC-1:0] steer_q, steer_d;
  logic               steer_en;
  assign steer_en = cfg_we_i && !in_guest;
  always_comb steer_d = steer_en ? cfg_steer_i : steer_q;
  always_ff @(posedge clk or negedge rst_nq) begin
    if (!rst_nq) steer_q <= '0;
    else         steer_q <= steer_d;
  end

  // event capture
  logic [NCAUSE-1:0] set_vec, clr_vec, pend;
  always_comb begin
    set_vec                = '0;
    set_vec[NUM_SRC-1:0]   = src_req_i;
    set_vec[C_DB]          = db_post_i;
    set_vec[C_PRIV]        = priv_trap_i && in_guest;
    set_vec[C_HCALL]       = sc_req_i && sc_hcall_i && in_guest;
    set_vec[C_GSYS]        = sc_req_i && !sc_hcall_i && in_guest;
  end

  irq_pend_bank #(.W(NCAUSE)) u_pend (
    .clk    (clk),
    .rst_n  (rst_nq),
    .set_i  (set_vec),
    .clr_i  (clr_vec),
    .pend_o (pend)
  );

  // target level and guest-side gating per cause
  logic [NCAUSE-1:0] to_guest, gs_gate, elig_hv, elig_gs;
  always_comb begin
    to_guest                = '0;
    to_guest[NUM_SRC-1:0]   = steer_q;
    to_guest[C_DB]          = 1'b1;
    to_guest[C_GSYS]        = 1'b1;
    gs_gate                 = '0;
    gs_gate[NUM_SRC-1:0]    = {NUM_SRC{guest_ie_i}};
    gs_gate[C_DB]           = db_en_i;
    gs_gate[C_GSYS]         = 1'b1;
    elig_hv = pend & ~to_guest;
    elig_gs = pend & to_guest & gs_gate & {NCAUSE{in_guest}};
  end

  logic [NCAUSE-1:0]  gnt_hv, gnt_gs;
  logic [CAUSE_W-1:0] idx_hv, idx_gs;
  logic               any_hv, any_gs;

  irq_prio_pick #(.W(NCAUSE), .IDX_W(CAUSE_W)) u_pick_hv (
    .req_i (elig_hv), .gnt_o (gnt_hv), .idx_o (idx_hv), .any_o (any_hv));
  irq_prio_pick #(.W(NCAUSE), .IDX_W(CAUSE_W)) u_pick_gs (
    .req_i (elig_gs), .gnt_o (gnt_gs), .idx_o (idx_gs), .any_o (any_gs));

  assign take_o       = any_hv || any_gs;
  assign take_hv_o    = any_hv;
  assign take_cause_o = any_hv ? idx_hv : idx_gs;
  assign clr_vec      = any_hv ? gnt_hv : gnt_gs;

  irq_mode_ctrl u_mode (
    .clk       (clk),
    .rst_n     (rst_nq),
    .take_i    (take_o),
    .take_hv_i (take_hv_o),
    .rfi_i     (rfi_i),
    .mode_o    (mode)
  );
  assign mode_o = mode;

  // R5: a guest-level take never happens in hypervisor mode
  assert_no_guest_take_in_hv_R5: assert property (
    @(posedge clk) disable iff (!rst_nq)
    (take_o && !take_hv_o) |-> (mode != MODE_HV));
  // R9: a pending hypervisor-level event always wins
  assert_hv_first_R9: assert property (
    @(posedge clk) disable iff (!rst_nq)
    (|(pend & ~to_guest)) |-> (take_o && take_hv_o));
  // R7: doorbell needs its enable and a guest mode
  assert_db_needs_enable_R7: assert property (
    @(posedge clk) disable iff (!rst_nq)
    (take_o && take_cause_o == CAUSE_W'(C_DB)) |-> (db_en_i && in_guest && !take_hv_o));
  // R6: the privileged-resource trap always lands at hypervisor level
  assert_priv_to_hv_R6: assert property (
    @(posedge clk) disable iff (!rst_nq)
    (take_o && take_cause_o == CAUSE_W'(C_PRIV)) |-> take_hv_o);
endmodule

// File: tb/irq_steer_unit_tb.sv
module irq_steer_unit_tb;
  localparam int NS = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NS-1:0] src_req = '0;
  logic          cfg_we = 1'b0;
  logic [NS-1:0] cfg_steer = '0;
  logic          guest_ie = 1'b0;
  logic          db_post = 1'b0;
  logic          db_en = 1'b0;
  logic          priv_trap = 1'b0;
  logic          sc_req = 1'b0;
  logic          sc_hcall = 1'b0;
  logic          rfi = 1'b0;
  logic          take, take_hv;
  logic [2:0]    cause;
  logic [1:0]    mode;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  irq_steer_unit #(.NUM_SRC(NS)) u_dut (
    .clk(clk), .rst_n(rst_n), .src_req_i(src_req), .cfg_we_i(cfg_we),
    .cfg_steer_i(cfg_steer), .guest_ie_i(guest_ie), .db_post_i(db_post),
    .db_en_i(db_en), .priv_trap_i(priv_trap), .sc_req_i(sc_req),
    .sc_hcall_i(sc_hcall), .rfi_i(rfi), .take_o(take), .take_hv_o(take_hv),
    .take_cause_o(cause), .mode_o(mode));

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      n_bad++;
      $display("FAIL watchdog act=%0d exp=0", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  task automatic nxt();
    @(negedge clk); #1;
  endtask

  task automatic chk(input string rq, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s act=%0d exp=%0d", rq, act, exp);
    end
  endtask

  // take strobe, level and cause together
  task automatic chk_take(input string rq, input int t, input int hv, input int c);
    chk({rq, " take"}, int'(take), t);
    if (t != 0) begin
      chk({rq, " level"}, int'(take_hv), hv);
      chk({rq, " cause"}, int'(cause), c);
    end
  endtask

  task automatic do_reset();
    src_req = '0; cfg_we = 0; guest_ie = 0; db_post = 0; db_en = 0;
    priv_trap = 0; sc_req = 0; sc_hcall = 0; rfi = 0;
    rst_n = 0; nxt(); nxt();
    rst_n = 1; nxt(); nxt(); nxt();
  endtask

  task automatic do_rfi();
    rfi = 1; nxt(); rfi = 0;
  endtask

  // reset, load steering, then walk down to mode m (2=HV,1=GS,0=GU)
  task automatic goto_mode(input int m, input logic [NS-1:0] cfg);
    do_reset();
    cfg_we = 1; cfg_steer = cfg; nxt(); cfg_we = 0;
    if (m != 2) do_rfi();
    if (m == 0) do_rfi();
  endtask

  initial begin
    do_reset();
    chk("R1 reset mode", int'(mode), 2);
    chk("R1 reset take", int'(take), 0);

    // sweep: steering pattern x mode x guest enable x source
    for (int cfg = 0; cfg < 16; cfg++) begin
      for (int m = 0; m < 3; m++) begin
        for (int ie = 0; ie < 2; ie++) begin
          for (int s = 0; s < NS; s++) begin
            automatic bit g = cfg[s];
            automatic int exp_t = (!g) ? 1 : ((m != 2 && ie == 1) ? 1 : 0);
            goto_mode(m, 4'(cfg));
            guest_ie = ie[0];
            src_req = '0; src_req[s] = 1'b1; nxt(); src_req = '0;
            chk_take(g ? "R5 guest src" : "R4 hv src", exp_t, g ? 0 : 1, s);
            if (exp_t == 1) begin
              nxt();
              chk("R2 mode after take", int'(mode), g ? 1 : 2);
              chk("R10 cleared after take", int'(take), 0);
            end else if (m == 2) begin
              nxt(); nxt();
              chk("R5 deferred in hv", int'(take), 0);
              guest_ie = 1; do_rfi();
              chk("R11 rfi from hv to gs", int'(mode), 1);
              chk_take("R5 delivered after return", 1, 0, s);
            end else begin
              chk("R5 masked by guest enable", int'(take), 0);
            end
          end
        end
      end
    end

    // R9: hypervisor level first, lowest index within a level
    goto_mode(1, 4'b1010);
    guest_ie = 1; src_req = 4'b1111; nxt(); src_req = '0;
    chk_take("R9 first hv", 1, 1, 0); nxt();
    chk_take("R9 second hv", 1, 1, 2); nxt();
    chk("R9 guest held in hv", int'(take), 0);
    do_rfi();
    chk("R11 rfi restores hv save", int'(mode), 2);
    goto_mode(1, 4'b1111);
    guest_ie = 1; src_req = 4'b1010; nxt(); src_req = '0;
    chk_take("R9 guest low index", 1, 0, 1); nxt();
    chk_take("R10 competitor kept", 1, 0, 3);

    // R3: steering write outside hypervisor mode is ignored
    goto_mode(1, 4'b0000);
    cfg_we = 1; cfg_steer = 4'b1111; nxt(); cfg_we = 0;
    guest_ie = 0; src_req = 4'b0001; nxt(); src_req = '0;
    chk_take("R3 write in guest ignored", 1, 1, 0);

    // R7: doorbell waits for its enable
    goto_mode(1, 4'b0000);
    db_en = 0; db_post = 1; nxt(); db_post = 0;
    nxt(); nxt();
    chk("R7 doorbell held", int'(take), 0);
    db_en = 1; #1;
    chk_take("R7 doorbell taken", 1, 0, NS);
    goto_mode(2, 4'b0000);
    db_en = 1; db_post = 1; nxt(); db_post = 0;
    chk("R7 doorbell held in hv", int'(take), 0);
    do_rfi();
    chk_take("R7 doorbell after return", 1, 0, NS);

    // R6: privileged-resource trap
    goto_mode(0, 4'b1111);
    priv_trap = 1; nxt(); priv_trap = 0;
    chk_take("R6 trap to hv", 1, 1, NS + 1); nxt();
    chk("R6 mode hv", int'(mode), 2);
    do_rfi();
    chk("R11 back to guest user", int'(mode), 0);
    goto_mode(2, 4'b1111);
    priv_trap = 1; nxt(); priv_trap = 0;
    chk("R6 ignored in hv", int'(take), 0);
    do_rfi();
    chk("R6 not kept pending", int'(take), 0);

    // R8: system calls
    goto_mode(0, 4'b0000);
    sc_hcall = 1; sc_req = 1; nxt(); sc_req = 0;
    chk_take("R8 hcall", 1, 1, NS + 2);
    goto_mode(0, 4'b0000);
    guest_ie = 0; sc_hcall = 0; sc_req = 1; nxt(); sc_req = 0;
    chk_take("R8 guest syscall", 1, 0, NS + 3); nxt();
    chk("R8 mode gs", int'(mode), 1);
    do_rfi();
    chk("R11 rfi from gs to gu", int'(mode), 0);
    do_rfi();
    chk("R11 rfi in gu ignored", int'(mode), 0);
    goto_mode(2, 4'b0000);
    sc_hcall = 1; sc_req = 1; nxt(); sc_req = 0;
    chk("R8 ignored in hv", int'(take), 0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule